// File: doc/BRIEF.md
# Track Jump Sequencer

This block steers the tracking actuator of an optical pickup through a multi-track jump. A host command gives the number of tracks to cross and the direction. The block opens the tracking loop and kicks the lens. It counts rising edges of the squared tracking zero-cross signal until it reaches roughly half the requested count. It then applies a reverse brake pulse, whose length in clock cycles the host sets.

After the brake pulse the loop closes. A settling period follows in which the equalizer drives the actuator with the servo gain raised. This period is measured in millisecond ticks. When it ends, a one-cycle completion pulse is raised and normal gain returns. Fast search is done by chaining single-track jumps: the next command is issued in the same cycle that the completion pulse is seen.

The zero-cross input is asynchronous and is synchronized inside the block. The drive levels and the equalizer itself are outside this block. The block only selects which of them acts, and with which polarity.

Top module: `track_jump_seq`

## Requirements
- R1: After reset, drive_sel_o is 0 (equalizer), servo_open_o, gain_up_o and done_o are 0, and drive_rev_o is 0.
- R2: In idle, a command (cmd_valid_i high, cmd_tracks_i nonzero) is taken at a clock edge. From the next cycle drive_sel_o is 1 (kick), servo_open_o is 1 and drive_rev_o equals the cmd_rev_i value that was sampled.
- R3: The kick lasts until ceil(N/2) rising edges of tzc_i have been counted, where N is the commanded track count (1→1, 4→2, 10→5, 32→16, 100→50). Falling edges are not counted.
- R4: The brake phase follows the kick directly. In it, drive_sel_o is 2 (brake), servo_open_o is 1 and drive_rev_o is the inverse of the commanded direction. It lasts exactly brake_len_i clock cycles, with brake_len_i sampled with the command. A value of 0 is treated as 1.
- R5: After the brake, the hold phase shows drive_sel_o = 0, servo_open_o = 0 and gain_up_o = 1. The hold phase lasts until HOLD_MS pulses of ms_tick_i have been taken (default 50).
- R6: When the hold ends, done_o is high for exactly one cycle, gain_up_o is low in that cycle, and the block is idle again.
- R7: A command presented while a jump is in progress has no effect on that jump's target, brake length or direction.
- R8: A command with cmd_tracks_i = 0 is ignored: the block stays idle.
- R9: A command given in the cycle where done_o is high is accepted, so single jumps can run back to back.
- R10: tzc_i edges outside the kick phase do not count toward the next jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Jump command strobe |
| cmd_tracks_i | input | TRK_W | Number of tracks to jump |
| cmd_rev_i | input | 1 | Jump direction, 1 = reverse |
| brake_len_i | input | BRK_W | Brake pulse width in clock cycles |
| tzc_i | input | 1 | Squared tracking zero-cross, asynchronous |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| drive_sel_o | output | 2 | 0 = equalizer, 1 = kick, 2 = brake |
| drive_rev_o | output | 1 | Polarity of the kick or brake drive |
| servo_open_o | output | 1 | Tracking loop open |
| gain_up_o | output | 1 | Raised servo gain during settling |
| done_o | output | 1 | One-cycle jump completion pulse |

## Verification
The bench targets the rounding of odd track counts. A design that floors instead would brake after zero edges on a one-track jump and one edge early on odd counts. It also covers zero and one cycle brake widths, where an off-by-one shows as a brake one cycle long or short, or as a brake that never ends. Commands issued mid-jump and zero-edge pulses sent during brake and hold are included. A design that reloads its registers, or keeps counting outside the kick, would end the following jump early. A chained command in the done cycle checks that back-to-back single jumps lose no cycle, and a zero-track command checks that the block does not start.

// File: rtl/tj_pkg.sv
package tj_pkg;
  typedef enum logic [1:0] {
    DRV_EQ    = 2'd0,
    DRV_KICK  = 2'd1,
    DRV_BRAKE = 2'd2
  } drv_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_KICK,
    ST_BRAKE,
    ST_HOLD
  } st_e;
endpackage

// File: rtl/tj_edge_det.sv
module tj_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tj_event_cnt.sv
module tj_event_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = inc_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || hit_o)  cnt_q <= '0;
    else if (inc_i)           cnt_q <= cnt_q + 1'b1;
  end

  // R3: the count never runs past its limit while active
  assert_cnt_below_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && limit_i != '0) |-> (cnt_q < limit_i));
endmodule

// File: rtl/track_jump_seq.sv
module track_jump_seq
  import tj_pkg::*;
#(
  parameter int TRK_W       = 8,
  parameter int BRK_W       = 16,
  parameter int HOLD_MS     = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [TRK_W-1:0] cmd_tracks_i,
  input  logic             cmd_rev_i,
  input  logic [BRK_W-1:0] brake_len_i,
  input  logic             tzc_i,
  input  logic             ms_tick_i,
  output logic [1:0]       drive_sel_o,
  output logic             drive_rev_o,
  output logic             servo_open_o,
  output logic             gain_up_o,
  output logic             done_o
);
  localparam int HLD_W = $clog2(HOLD_MS + 1);

  st_e              st_q;
  logic [TRK_W-1:0] tgt_q;
  logic [BRK_W-1:0] brk_q;
  logic             rev_q;
  logic             done_q;
  logic             tzc_rise, trk_hit, brk_hit, hld_hit;
  logic             start;
  drv_e             drv;

  tj_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(tzc_i), .rise_o(tzc_rise)
  );

  tj_event_cnt #(.W(TRK_W)) u_trk_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(st_q != ST_KICK),
    .inc_i(tzc_rise), .limit_i(tgt_q), .hit_o(trk_hit)
  );

  tj_event_cnt #(.W(BRK_W)) u_brk_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(st_q != ST_BRAKE),
    .inc_i(1'b1), .limit_i(brk_q), .hit_o(brk_hit)
  );

  tj_event_cnt #(.W(HLD_W)) u_hld_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(st_q != ST_HOLD),
    .inc_i(ms_tick_i), .limit_i(HLD_W'(HOLD_MS)), .hit_o(hld_hit)
  );

  assign start = (st_q == ST_IDLE) && cmd_valid_i && (cmd_tracks_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tgt_q  <= '0;
      brk_q  <= '0;
      rev_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          // kick target: ceil(N/2)
          tgt_q <= {1'b0, cmd_tracks_i[TRK_W-1:1]} + TRK_W'(cmd_tracks_i[0]);
          brk_q <= (brake_len_i == '0) ? BRK_W'(1) : brake_len_i;
          rev_q <= cmd_rev_i;
          st_q  <= ST_KICK;
        end
        ST_KICK:  if (trk_hit) st_q <= ST_BRAKE;
        ST_BRAKE: if (brk_hit) st_q <= ST_HOLD;
        ST_HOLD: if (hld_hit) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_KICK:  drv = DRV_KICK;
      ST_BRAKE: drv = DRV_BRAKE;
      default:  drv = DRV_EQ;
    endcase
  end

  assign drive_sel_o  = drv;
  assign drive_rev_o  = (st_q == ST_KICK) ? rev_q : ((st_q == ST_BRAKE) ? ~rev_q : 1'b0);
  assign servo_open_o = (st_q == ST_KICK) || (st_q == ST_BRAKE);
  assign gain_up_o    = (st_q == ST_HOLD);
  assign done_o       = done_q;

  assert_kick_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_sel_o == DRV_KICK) |-> servo_open_o);

  assert_brake_after_kick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_sel_o == DRV_BRAKE && $past(drive_sel_o) != DRV_BRAKE) |-> ($past(drive_sel_o) == DRV_KICK));

  assert_gain_closed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_up_o |-> (!servo_open_o && drive_sel_o == DRV_EQ));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(gain_up_o) && !gain_up_o));

  assert_dir_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_sel_o == DRV_KICK && $past(drive_sel_o) == DRV_KICK) |-> $stable(drive_rev_o));
endmodule

// File: tb/track_jump_seq_test.sv
module track_jump_seq_test;
  localparam int TRK_W    = 8;
  localparam int BRK_W    = 16;
  localparam int HOLD_MS  = 50;
  localparam int TICK_DIV = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [TRK_W-1:0] cmd_tracks = '0;
  logic             cmd_rev = 1'b0;
  logic [BRK_W-1:0] brake_len = '0;
  logic             tzc = 1'b0;
  logic             ms_tick = 1'b0;
  logic [1:0]       drive_sel;
  logic             drive_rev, servo_open, gain_up, done;

  int checks = 0, fails = 0;
  int exp_tgt = 0, exp_brk = 0, rises_sent = 0;
  logic exp_rev = 1'b0;
  logic mon_en = 1'b0;

  always #5 clk = ~clk;

  track_jump_seq #(.TRK_W(TRK_W), .BRK_W(BRK_W), .HOLD_MS(HOLD_MS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_tracks_i(cmd_tracks),
    .cmd_rev_i(cmd_rev), .brake_len_i(brake_len), .tzc_i(tzc), .ms_tick_i(ms_tick),
    .drive_sel_o(drive_sel), .drive_rev_o(drive_rev), .servo_open_o(servo_open),
    .gain_up_o(gain_up), .done_o(done)
  );

  function automatic int kick_target(int n);
    return (n + 1) / 2;
  endfunction

  function automatic int brake_width(int b);
    return (b == 0) ? 1 : b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor and tick generator
  logic [1:0] prev_drv = 2'd0;
  logic prev_gain = 1'b0, prev_done = 1'b0;
  int brk_run = 0, hold_ticks = 0, tick_div = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_gain && ms_tick) hold_ticks++;
      if (drive_sel == 2'd2) brk_run++;
      if (prev_drv == 2'd1 && drive_sel == 2'd2) begin
        check(rises_sent == exp_tgt, "R3 kick edges", rises_sent, exp_tgt);
        check(drive_rev == ~exp_rev && servo_open, "R4 brake polarity", drive_rev, ~exp_rev);
      end
      if (prev_drv == 2'd2 && drive_sel != 2'd2) begin
        check(brk_run == exp_brk, "R4 brake width", brk_run, exp_brk);
        check(gain_up && !servo_open && drive_sel == 2'd0, "R5 hold outputs",
              {drive_sel, servo_open, gain_up}, 4'b0001);
        brk_run = 0;
        hold_ticks = 0;
      end
      if (done) begin
        check(hold_ticks == HOLD_MS, "R5 hold ticks", hold_ticks, HOLD_MS);
        check(!gain_up && drive_sel == 2'd0, "R6 done cycle outputs", gain_up, 0);
        hold_ticks = 0;
      end
      if (prev_done && done) check(1'b0, "R6 done width", 2, 1);
      prev_drv  = drive_sel;
      prev_gain = gain_up;
      prev_done = done;
    end
    tick_div = (tick_div == TICK_DIV - 1) ? 0 : tick_div + 1;
    ms_tick  = (tick_div == 0);
  end

  task automatic pulse(input bit counted);
    tzc = 1'b1;
    if (counted) rises_sent++;
    repeat (4 + $urandom_range(3)) @(negedge clk);
    tzc = 1'b0;
    repeat (4 + $urandom_range(3)) @(negedge clk);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) check(1'b0, "R6 done never seen", 0, 1);
  endtask

  // issues a jump; assumes caller is at a negedge
  task automatic jump(input int n, input bit rev, input int brk, input bit disturb, input bit chain_next);
    cmd_valid  = 1'b1;
    cmd_tracks = TRK_W'(n);
    cmd_rev    = rev;
    brake_len  = BRK_W'(brk);
    exp_tgt    = kick_target(n);
    exp_brk    = brake_width(brk);
    exp_rev    = rev;
    rises_sent = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(drive_sel == 2'd1 && servo_open, "R2 kick start", drive_sel, 1);
    check(drive_rev == rev, "R2 kick polarity", drive_rev, rev);
    if (disturb) begin
      // R7: mid-jump command with other values
      cmd_valid  = 1'b1;
      cmd_tracks = 8'd1;
      cmd_rev    = ~rev;
      brake_len  = 16'd3;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    for (int i = 0; i < exp_tgt; i++) begin
      if (i > 0) check(drive_sel == 2'd1, "R3 still kicking", drive_sel, 1);
      pulse(1'b1);
    end
    // R10: stray edges after the kick
    pulse(1'b0);
    pulse(1'b0);
    wait_done();
    if (!chain_next) begin
      @(negedge clk);
      check(drive_sel == 2'd0 && !servo_open && !gain_up && !done, "R6 idle after done",
            drive_sel, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(drive_sel == 2'd0 && !servo_open && !gain_up && !done && !drive_rev,
          "R1 reset outputs", {drive_sel, servo_open, gain_up, done}, 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    check(drive_sel == 2'd0 && !servo_open, "R1 idle after reset", drive_sel, 0);

    // R8: zero-track command
    cmd_valid = 1'b1; cmd_tracks = '0; brake_len = 16'd4;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(drive_sel == 2'd0 && !servo_open, "R8 zero tracks ignored", drive_sel, 0);

    // R10: edges in idle
    pulse(1'b0);
    repeat (4) @(negedge clk);

    jump(1,   1'b0, 6,  1'b0, 1'b0);
    jump(4,   1'b1, 12, 1'b0, 1'b0);
    jump(10,  1'b0, 0,  1'b0, 1'b0);
    jump(32,  1'b1, 1,  1'b0, 1'b0);
    jump(100, 1'b0, 40, 1'b0, 1'b0);
    jump(7,   1'b1, 9,  1'b1, 1'b0);
    jump(255, 1'b0, 2,  1'b0, 1'b0);

    // R9: chained single jumps
    jump(1, 1'b0, 3, 1'b0, 1'b1);
    jump(1, 1'b0, 3, 1'b0, 1'b1);
    jump(1, 1'b1, 3, 1'b0, 1'b0);

    for (int k = 0; k < 12; k++) begin
      jump(1 + $urandom_range(60), 1'($urandom_range(1)), $urandom_range(150),
           1'($urandom_range(1)), 1'b0);
    end

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule